// File: doc/BRIEF.md
# I2C Slave for a Four-Channel Bus Switch, with Identity Readback

This block is the bus-facing logic of a four-channel I2C bus switch. It watches oversampled SCL and SDA lines and answers as a slave at a 7-bit address given on a port. A master that writes to that address sets an 8-bit control byte. The four low bits of that byte drive four channel-enable outputs. Reading the address returns the byte.

The block also takes part in the reserved identity query. The master first sends the reserved write address. It then sends a byte that carries the address of the slave it wants to query. Only the slave whose own address matches that byte arms itself. After a repeated START, the master sends the reserved read address. The armed slave then streams a 24-bit identity made of three fields, sent in this order:

- a 12-bit manufacturer field of zeros,
- a 9-bit part number, set by a parameter,
- a 3-bit revision of zeros.

While the master keeps acknowledging, the identity repeats from its first byte.

SDA is driven open-drain. The `sda_oe` output asserts to pull the line low and never drives it high. The reset is synchronous and active low.

Top module: `i2c_idmux_slave`

## Requirements
- R1: In the first cycle after reset is released, `chan_en` is 0000 and `sda_oe` is low. The control byte reads back as 0x00.
- R2: The block acknowledges an address byte whose bits 7:1 equal `own_addr` and whose bit 0 (R/W) is 0. It acknowledges every data byte that follows and stores it. `chan_en[n]` then equals bit n of the stored byte, for n = 0..3. The outputs change only while SCL is low, during the acknowledge of that byte.
- R3: When one transfer writes several bytes, only the last one is kept. Bits 7:4 of the byte have no effect on `chan_en`, but they are stored and returned on readback.
- R4: An address byte equal to `own_addr` with R/W = 1 is acknowledged. The slave then sends the stored control byte MSB first. It sends the same byte again after each master ACK and stops driving after a master NACK.
- R5: An address byte matching neither `own_addr` nor the reserved address 1111100 is not acknowledged. Its data bytes leave the control byte and `chan_en` unchanged.
- R6: The reserved write address byte 0xF8 is always acknowledged. The next byte is acknowledged only if its bits 7:1 equal `own_addr`; bit 0 is ignored. Only that acknowledge arms the identity readback. Neither byte changes the control byte.
- R7: In an armed slave, a repeated START followed by 0xF9 is acknowledged. The slave then sends these bytes in order:
  - byte 0 = 0x00,
  - byte 1 = {0000, PART[8:5]},
  - byte 2 = {PART[4:0], 000}.

  After byte 2 it returns to byte 0 while the master acknowledges, and it releases SDA after a master NACK.
- R8: 0xF9 is not acknowledged unless the slave was armed before the START that came just before it. A STOP clears the armed state.
- R9: The slave pulls SDA low for the whole ninth clock of every byte it acknowledges and releases it after that clock. It never pulls SDA low while the master sends a 1 data bit. It starts pulling SDA low only while SCL is low.
- R10: A START that arrives before a byte's acknowledge clock discards that byte. This includes a START inside the eighth bit's high phase. The control byte and `chan_en` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr | input | 7 | This slave's 7-bit bus address |
| sda_oe | output | 1 | When high, pull SDA low |
| chan_en | output | 4 | Enable for downstream channels 3..0 |

## Verification
The control-byte update and the start of the ACK drive are triggered by the same synchronized SCL falling edge. A START arriving just before that edge must cancel both.

The bench provokes this in two ways:
- It raises SCL for the eighth bit of a write byte and then pulls SDA low during that high phase, so the START replaces the falling edge that would commit the byte.
- It aborts another byte after four bits.

The per-clock reference model of `chan_en` must stay unchanged through both aborts, and a later readback must still return the earlier byte.

// File: rtl/i2c_idmux_pkg.sv
// Package: shared types and constants of the I2C bus-switch slave.
// Assumes: 7-bit addressing; byte-wide transfers.
package i2c_idmux_pkg;

    // Reserved 7-bit address used by the identity query
    localparam logic [6:0] RSV_ADDR = 7'b1111100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } st_e;

    // What follows the acknowledge clock
    typedef enum logic [1:0] {
        NX_HOLD,
        NX_RX,
        NX_TX
    } next_e;

    // Meaning of a received data byte
    typedef enum logic {
        RX_CTRL,
        RX_ID_TGT
    } rx_mode_e;

    // Source of transmitted bytes
    typedef enum logic {
        TX_CTRL,
        TX_ID
    } tx_src_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through a flop chain.
// Produces single-cycle SCL edge strobes and START/STOP strobes.
// Assumes: lines idle high; no glitch filter needed.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // First synchronizer stage, reset to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
        end
    end

    // Remaining synchronizer stages
    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[k] <= 1'b1;
                    sda_pipe[k] <= 1'b1;
                end else begin
                    scl_pipe[k] <= scl_pipe[k-1];
                    sda_pipe[k] <= sda_pipe[k-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Previous synchronized levels, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition strobes
    always_comb begin
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_id_store.sv
// Module: i2c_id_store
// Packs the manufacturer, part and revision fields into one word.
// Returns the byte selected by `sel`, MSB-first byte order.
// Assumes: total field width is a whole number of bytes.
module i2c_id_store #(
    parameter int          MFR_W   = 12,
    parameter int          PART_W  = 9,
    parameter int          REV_W   = 3,
    parameter int          SEL_W   = 2,
    parameter logic [11:0] MFR_VAL = 12'h000,
    parameter logic [8:0]  PART_ID = 9'h10A,
    parameter logic [2:0]  REV_VAL = 3'h0
) (
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       byte_o
);

    localparam int WORD_W = MFR_W + PART_W + REV_W;
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] word;

    // Concatenate the identity fields in transmit order
    assign word = {MFR_VAL[MFR_W-1:0], PART_ID[PART_W-1:0], REV_VAL[REV_W-1:0]};

    // Select one byte, counting from the most significant end
    always_comb begin
        byte_o = 8'h00;
        for (int b = 0; b < NBYTES; b++) begin
            if (sel == SEL_W'(b)) byte_o = word[WORD_W-1-8*b -: 8];
        end
    end

endmodule

// File: rtl/i2c_ctrl_reg.sv
// Module: i2c_ctrl_reg
// Holds the 8-bit control byte and drives the channel enables from its low bits.
// Assumes: wr_en is a single-cycle strobe from the protocol engine.
module i2c_ctrl_reg #(
    parameter int CHANNELS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_data,
    output logic [7:0]          ctrl_q,
    output logic [CHANNELS-1:0] chan_en
);

    // Store the last written byte; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= 8'h00;
        else if (wr_en) ctrl_q <= wr_data;
    end

    assign chan_en = ctrl_q[CHANNELS-1:0];

endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: i2c_slave_fsm
// Byte-level I2C slave protocol engine.
//   Decodes the address byte and acknowledges matching bytes.
//   Commits written bytes to the control register.
//   Streams the control byte or the identity bytes on reads.
// Assumes: edge and START/STOP strobes come from i2c_line_sync.
// START or STOP from any state restarts the engine; STOP also disarms.
module i2c_slave_fsm
    import i2c_idmux_pkg::*;
#(
    parameter int ID_BYTES = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [6:0]       own_addr,
    input  logic [7:0]       ctrl_q,
    input  logic [7:0]       id_byte,
    output logic [SEL_W-1:0] id_sel,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_oe,
    output logic             armed,
    output st_e              st
);

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(ID_BYTES - 1);

    logic [3:0]       cnt;
    logic [7:0]       shreg;
    next_e            nxt;
    rx_mode_e         rx_mode;
    tx_src_e          tx_src;
    logic [SEL_W-1:0] id_idx;
    logic             id_ok;
    logic             mack_ok;

    logic             hit_own;
    logic             hit_rsv;
    logic [SEL_W-1:0] load_idx;
    logic [7:0]       load_byte;

    // Address decode of the byte in the shift register
    always_comb begin
        hit_own = (shreg[7:1] == own_addr);
        hit_rsv = (shreg[7:1] == RSV_ADDR);
    end

    // Pick which byte to load next: the first, or the following identity byte
    always_comb begin
        if (st == ST_MACK) load_idx = (id_idx == LAST_IDX) ? '0 : id_idx + 1'b1;
        else               load_idx = '0;
        load_byte = (tx_src == TX_ID) ? id_byte : ctrl_q;
    end

    assign id_sel = load_idx;

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            nxt     <= NX_HOLD;
            rx_mode <= RX_CTRL;
            tx_src  <= TX_CTRL;
            id_idx  <= '0;
            id_ok   <= 1'b0;
            armed   <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
                id_ok  <= armed;
                armed  <= 1'b0;
            end else if (stop_ev) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
                id_ok  <= 1'b0;
                armed  <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (st == ST_ADDR) begin
                                id_ok <= 1'b0;
                                if (hit_rsv && !shreg[0]) begin
                                    st      <= ST_ACK;
                                    sda_oe  <= 1'b1;
                                    nxt     <= NX_RX;
                                    rx_mode <= RX_ID_TGT;
                                end else if (hit_rsv && id_ok) begin
                                    st     <= ST_ACK;
                                    sda_oe <= 1'b1;
                                    nxt    <= NX_TX;
                                    tx_src <= TX_ID;
                                end else if (hit_own) begin
                                    st      <= ST_ACK;
                                    sda_oe  <= 1'b1;
                                    nxt     <= shreg[0] ? NX_TX : NX_RX;
                                    rx_mode <= RX_CTRL;
                                    tx_src  <= TX_CTRL;
                                end else begin
                                    st <= ST_HOLD;
                                end
                            end else if (rx_mode == RX_CTRL) begin
                                st      <= ST_ACK;
                                sda_oe  <= 1'b1;
                                nxt     <= NX_RX;
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                            end else if (hit_own) begin
                                st     <= ST_ACK;
                                sda_oe <= 1'b1;
                                nxt    <= NX_HOLD;
                                armed  <= 1'b1;
                            end else begin
                                st <= ST_HOLD;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            unique case (nxt)
                                NX_RX: begin
                                    st  <= ST_RX;
                                    cnt <= '0;
                                end
                                NX_TX: begin
                                    st     <= ST_TX;
                                    cnt    <= '0;
                                    shreg  <= load_byte;
                                    sda_oe <= ~load_byte[7];
                                    id_idx <= load_idx;
                                end
                                default: st <= ST_HOLD;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                            end else begin
                                cnt    <= cnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                st     <= ST_TX;
                                cnt    <= '0;
                                shreg  <= load_byte;
                                sda_oe <= ~load_byte[7];
                                id_idx <= load_idx;
                            end else begin
                                st <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_idmux_slave.sv
// Module: i2c_idmux_slave (top)
// I2C slave for a four-channel bus switch.
// Holds a writable and readable control byte and answers the reserved identity query.
// Assumes: SDA and SCL arrive asynchronously and are oversampled by clk.
// The system clock runs many times faster than SCL.
module i2c_idmux_slave #(
    parameter int         CHANNELS    = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [8:0] PART_ID     = 9'h10A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [6:0]          own_addr,
    output logic                sda_oe,
    output logic [CHANNELS-1:0] chan_en
);

    import i2c_idmux_pkg::*;

    localparam int MFR_W    = 12;
    localparam int PART_W   = 9;
    localparam int REV_W    = 3;
    localparam int ID_BYTES = (MFR_W + PART_W + REV_W) / 8;
    localparam int SEL_W    = $clog2(ID_BYTES);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [SEL_W-1:0] id_sel;
    logic [7:0]       id_byte;
    logic [7:0]       ctrl_q;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic             armed;
    st_e              st;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_id_store #(
        .MFR_W   (MFR_W),
        .PART_W  (PART_W),
        .REV_W   (REV_W),
        .SEL_W   (SEL_W),
        .MFR_VAL (12'h000),
        .PART_ID (PART_ID),
        .REV_VAL (3'h0)
    ) u_id (
        .sel    (id_sel),
        .byte_o (id_byte)
    );

    i2c_slave_fsm #(.ID_BYTES(ID_BYTES), .SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .own_addr (own_addr),
        .ctrl_q   (ctrl_q),
        .id_byte  (id_byte),
        .id_sel   (id_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe),
        .armed    (armed),
        .st       (st)
    );

    i2c_ctrl_reg #(.CHANNELS(CHANNELS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .chan_en (chan_en)
    );

endmodule

// File: rtl/i2c_idmux_chk.sv
// Module: i2c_idmux_chk
// Assertion checker, bound to i2c_idmux_slave.
module i2c_idmux_chk
    import i2c_idmux_pkg::*;
#(
    parameter int CHANNELS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                stop_ev,
    input logic                armed,
    input logic                sda_oe,
    input logic [CHANNELS-1:0] chan_en,
    input st_e                 st
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_en == '0 && !sda_oe));

    // R9
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R2
    chan_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> !scl_s);

    // R8
    stop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !armed);

    // R6
    arm_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> sda_oe);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_HOLD) |-> !sda_oe);

endmodule

bind i2c_idmux_slave i2c_idmux_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .stop_ev (stop_ev),
    .armed   (armed),
    .sda_oe  (sda_oe),
    .chan_en (chan_en),
    .st      (st)
);

// File: tb/sim_i2c_idmux_slave.sv
// Bench for i2c_idmux_slave.
// A behavioural bus master drives the lines.
// A reference model of the control byte is compared with chan_en on every clock.
`timescale 1ns/1ps
module sim_i2c_idmux_slave;

    localparam int         Q    = 10;
    localparam logic [6:0] OWN  = 7'h2A;
    localparam logic [8:0] PART = 9'h1B5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [3:0] chan_en;
    wire        sda_line = m_sda & ~sda_oe;

    int   tests = 0;
    int   fails = 0;
    int   bus_err = 0;
    bit   settle = 1'b0;
    bit   mis_seen = 1'b0;
    bit   done = 1'b0;
    logic [7:0] model_ctrl = 8'h00;

    always #4 clk = ~clk;

    i2c_idmux_slave #(.PART_ID(PART)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .own_addr (OWN),
        .sda_oe   (sda_oe),
        .chan_en  (chan_en)
    );

    // Per-clock comparison of chan_en with the model (R2, R3, R5, R10)
    always @(negedge clk) begin
        if (rst_n && settle && chan_en !== model_ctrl[3:0] && !mis_seen) begin
            mis_seen = 1'b1;
            $display("FAIL R2 per-clock chan_en: got %h expected %h at %0t", chan_en, model_ctrl[3:0], $time);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq(Q/2);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q/2);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq(Q/2);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda = b; wq(Q/2);
        m_scl = 1'b1; wq(Q/2);
        r = sda_line; wq(Q/2);
        m_scl = 1'b0; wq(Q/2);
    endtask

    // Sends 8 bits; returns 1 if the slave acknowledged
    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(b[i], r);
            if (r !== b[i]) bus_err++;
        end
        m_bit(1'b1, r);
        ack = (r === 1'b0);
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            b[i] = r;
        end
        m_bit(~mack, r);
    endtask

    // Write transfer; updates the model after each acknowledged byte
    task automatic wr_ctrl(input logic [7:0] d, input string req);
        logic a;
        settle = 1'b0;
        m_wbyte(d, a);
        chk({req, " data ack"}, a, 1'b1);
        if (a) model_ctrl = d;
        wq(2);
        settle = 1'b1;
    endtask

    task automatic read_ctrl(input logic [7:0] exp, input string req);
        logic       a;
        logic [7:0] d;
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        chk({req, " read addr ack"}, a, 1'b1);
        m_rbyte(1'b1, d);
        chk({req, " read byte 0"}, d, exp);
        m_rbyte(1'b0, d);
        chk({req, " read byte 1 repeat"}, d, exp);
        m_stop();
        chk({req, " released after NACK"}, sda_line, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic       r;
        logic [7:0] d;
        wq(6);
        rst_n = 1'b1;
        wq(1);
        // R1: reset state
        chk("R1 chan_en after reset", chan_en, 4'h0);
        chk("R1 sda released after reset", sda_oe, 1'b0);
        settle = 1'b1;
        read_ctrl(8'h00, "R1");

        // R2: single write
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk("R2 own write addr ack", a, 1'b1);
        wr_ctrl(8'h05, "R2");
        m_stop();
        chk("R2 chan_en", chan_en, 4'h5);

        // R3: several bytes, last one kept; upper nibble stored
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        wr_ctrl(8'h03, "R3");
        wr_ctrl(8'hFA, "R3");
        wr_ctrl(8'h9C, "R3");
        m_stop();
        chk("R3 chan_en last byte", chan_en, 4'hC);
        // R4: readback repeats the control byte
        read_ctrl(8'h9C, "R4");

        // R5: foreign address ignored
        m_start();
        settle = 1'b0;
        m_wbyte({7'h2B, 1'b0}, a);
        chk("R5 foreign addr nack", a, 1'b0);
        m_wbyte(8'h0F, a);
        chk("R5 foreign data nack", a, 1'b0);
        settle = 1'b1;
        m_stop();
        chk("R5 chan_en unchanged", chan_en, 4'hC);

        // R6/R7: identity query, target bit 0 set (don't care)
        m_start();
        m_wbyte(8'hF8, a);
        chk("R6 reserved write ack", a, 1'b1);
        m_wbyte({OWN, 1'b1}, a);
        chk("R6 target match ack", a, 1'b1);
        m_start();
        m_wbyte(8'hF9, a);
        chk("R7 reserved read ack", a, 1'b1);
        m_rbyte(1'b1, d);
        chk("R7 id byte 0", d, 8'h00);
        m_rbyte(1'b1, d);
        chk("R7 id byte 1", d, {4'h0, PART[8:5]});
        m_rbyte(1'b1, d);
        chk("R7 id byte 2", d, {PART[4:0], 3'b000});
        m_rbyte(1'b1, d);
        chk("R7 id wrap byte 0", d, 8'h00);
        m_rbyte(1'b0, d);
        chk("R7 id wrap byte 1", d, {4'h0, PART[8:5]});
        m_bit(1'b1, r);
        chk("R7 released after NACK", r, 1'b1);
        m_stop();
        chk("R6 chan_en untouched by query", chan_en, 4'hC);

        // R6/R8: mismatched target does not arm
        m_start();
        m_wbyte(8'hF8, a);
        chk("R6 reserved write ack 2", a, 1'b1);
        m_wbyte({7'h2B, 1'b0}, a);
        chk("R6 target mismatch nack", a, 1'b0);
        m_start();
        m_wbyte(8'hF9, a);
        chk("R8 unarmed read nack", a, 1'b0);
        m_stop();

        // R8: STOP clears the armed state
        m_start();
        m_wbyte(8'hF8, a);
        m_wbyte({OWN, 1'b0}, a);
        chk("R8 arm ack", a, 1'b1);
        m_stop();
        m_start();
        m_wbyte(8'hF9, a);
        chk("R8 read after STOP nack", a, 1'b0);
        m_stop();

        // R10: START after four data bits
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        settle = 1'b1;
        for (int i = 0; i < 4; i++) m_bit(1'b0, r);
        m_start();
        m_stop();
        chk("R10 abort after 4 bits", chan_en, 4'hC);

        // R10: START inside the eighth bit's high phase
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        for (int i = 0; i < 7; i++) m_bit(1'b0, r);
        m_sda = 1'b1; wq(Q/2);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q/2);
        m_wbyte({OWN, 1'b1}, a);
        chk("R10 addr after abort start ack", a, 1'b1);
        m_rbyte(1'b0, d);
        chk("R10 byte kept after late abort", d, 8'h9C);
        m_stop();
        chk("R10 chan_en after late abort", chan_en, 4'hC);

        // R9: slave never held SDA low while a 1 data bit was sent
        chk("R9 no drive outside ACK", bus_err, 0);
        chk("R2 per-clock model agreement", mis_seen, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule